// File: doc/BRIEF.md
# Shift and Rotate Unit with Carry

This block is the shifter slice of an integer datapath. It takes one 32-bit value and moves its bits according to a three-bit operation code. There are five operations: logical shift left, logical shift right, arithmetic shift right, rotate right, and a one-place rotate right that passes through the incoming carry. The shift amount comes from one of two places. It can be a small immediate field, or it can be the low byte of a second register value, which allows amounts up to 255. Every amount in that range has a defined result and carry-out.

When the set-flags input is high, the negative, zero and carry flags are recomputed from the result. When it is low, those three flags keep their incoming values. The overflow flag always passes through unchanged. The datapath is combinational. With the default parameter setting, a register stage sits at the output, so results appear one clock after the inputs.

Top module: `shift_carry_unit`

## Requirements
- R1: LSL (op 0) or LSR (op 1) by an amount n from 1 to 31 gives the operand shifted with zero fill. The carry is the last bit shifted out: operand bit 32-n for LSL, operand bit n-1 for LSR.
- R2: For ops 0 to 3, an amount of zero returns the operand unchanged, and the carry equals carry_in. LSL with immediate zero is therefore a plain move.
- R3: LSL or LSR by exactly 32 gives zero, with carry equal to operand bit 0 for LSL and operand bit 31 for LSR. Any amount of 33 or more gives zero with carry 0.
- R4: RRX (op 4) gives {carry_in, operand[31:1]} with carry equal to operand bit 0. It ignores both amount sources.
- R5: ASR (op 2) by n from 1 to 31 shifts right and fills with the sign bit, with carry equal to operand bit n-1. ASR by 32 or more gives every bit equal to the sign bit, and the carry is also the sign bit.
- R6: ROR (op 3) rotates by the amount modulo 32. For a nonzero amount the carry equals result bit 31. A nonzero multiple of 32 returns the operand unchanged, with carry equal to operand bit 31.
- R7: With use_reg_amt=0 the amount is the 6-bit immediate. With use_reg_amt=1 it is rs_val[7:0], and rs_val[31:8] has no effect.
- R8: With set_flags=1: flag_n is result bit 31, flag_z is 1 exactly when the result is zero, and flag_c is the shift carry. With set_flags=0, flag_n, flag_z and flag_c equal n_in, z_in and carry_in.
- R9: flag_v always equals v_in.
- R10: Outputs are registered, with one clock of latency. A synchronous active-high reset clears every output to zero.
- R11: Op codes 5 to 7 return the operand unchanged, with carry equal to carry_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 3 | 0 LSL, 1 LSR, 2 ASR, 3 ROR, 4 RRX |
| use_reg_amt | input | 1 | 1: amount from rs_val low byte; 0: from imm_amt |
| imm_amt | input | 6 | Immediate shift amount |
| rs_val | input | 32 | Register holding the shift amount |
| operand | input | 32 | Value to shift |
| carry_in | input | 1 | Incoming carry flag |
| set_flags | input | 1 | Update N, Z, C from the operation |
| n_in | input | 1 | Incoming negative flag |
| z_in | input | 1 | Incoming zero flag |
| v_in | input | 1 | Incoming overflow flag |
| result | output | 32 | Shifted value |
| flag_n | output | 1 | Negative flag out |
| flag_z | output | 1 | Zero flag out |
| flag_c | output | 1 | Carry flag out |
| flag_v | output | 1 | Overflow flag out |

## Verification
The clocked assertions assume that every input is free of unknowns and holds steady over each rising edge. They also assume the registered output stage is present, because they compare outputs with the inputs of the previous cycle. The bench meets these assumptions by changing inputs only on the falling clock edge and always driving defined values. It samples outputs on the next falling edge. The stimulus covers amounts of 0, 1, 31, 32, 33, 64 and 255, register amounts whose high bits are set, and the unused op codes.

// File: rtl/shu_pkg.sv
package shu_pkg;
  typedef enum logic [2:0] {
    OP_LSL = 3'd0,
    OP_LSR = 3'd1,
    OP_ASR = 3'd2,
    OP_ROR = 3'd3,
    OP_RRX = 3'd4
  } shift_op_e;
endpackage

// File: rtl/shu_amt_sel.sv
module shu_amt_sel #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 6,
  parameter int AMT_W  = 8
) (
  input  logic              use_reg,
  input  logic [IMM_W-1:0]  imm_amt,
  input  logic [DATA_W-1:0] rs_val,
  output logic [AMT_W-1:0]  amt
);
  // Only the low byte of the register counts; the rest is dropped here.
  logic unused_hi;
  assign unused_hi = ^rs_val[DATA_W-1:AMT_W];

  always_comb begin
    if (use_reg) amt = rs_val[AMT_W-1:0];
    else         amt = AMT_W'(imm_amt);
  end
endmodule

// File: rtl/shu_core.sv
module shu_core
  import shu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input  logic [2:0]        op,
  input  logic [AMT_W-1:0]  amt,
  input  logic [DATA_W-1:0] a,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              cout
);
  localparam int ROT_W = $clog2(DATA_W);

  shift_op_e op_e;
  assign op_e = shift_op_e'(op);

  // Saturated amounts: past DATA_W+1 logical results cannot change.
  logic [AMT_W-1:0] lin_amt, asr_amt;
  always_comb begin
    lin_amt = (amt > AMT_W'(DATA_W + 1)) ? AMT_W'(DATA_W + 1) : amt;
    asr_amt = (amt > AMT_W'(DATA_W))     ? AMT_W'(DATA_W)     : amt;
  end

  // One guard bit on the side bits leave, so carry falls out of the shift.
  logic [DATA_W:0]        ext_l, ext_r;
  logic signed [DATA_W:0] ext_a;
  assign ext_l = {1'b0, a} << lin_amt;
  assign ext_r = {a, 1'b0} >> lin_amt;
  assign ext_a = $signed({a, 1'b0}) >>> asr_amt;

  logic [ROT_W-1:0]  rot;
  logic [ROT_W:0]    rot_back;
  logic [DATA_W-1:0] rot_res;
  assign rot      = amt[ROT_W-1:0];
  assign rot_back = (ROT_W+1)'(DATA_W) - {1'b0, rot};
  assign rot_res  = (a >> rot) | (a << rot_back);

  always_comb begin
    res  = a;
    cout = cin;
    if (op_e == OP_RRX) begin
      res  = {cin, a[DATA_W-1:1]};
      cout = a[0];
    end else if (amt != '0) begin
      case (op_e)
        OP_LSL: begin res = ext_l[DATA_W-1:0]; cout = ext_l[DATA_W]; end
        OP_LSR: begin res = ext_r[DATA_W:1];   cout = ext_r[0];      end
        OP_ASR: begin res = ext_a[DATA_W:1];   cout = ext_a[0];      end
        OP_ROR: begin res = rot_res;           cout = rot_res[DATA_W-1]; end
        default: begin res = a; cout = cin; end
      endcase
    end
  end
endmodule

// File: rtl/shu_flags.sv
module shu_flags #(
  parameter int DATA_W = 32
) (
  input  logic              set_flags,
  input  logic [DATA_W-1:0] res,
  input  logic              cout,
  input  logic              n_in,
  input  logic              z_in,
  input  logic              c_in,
  output logic              n_out,
  output logic              z_out,
  output logic              c_out
);
  always_comb begin
    if (set_flags) begin
      n_out = res[DATA_W-1];
      z_out = (res == '0);
      c_out = cout;
    end else begin
      n_out = n_in;
      z_out = z_in;
      c_out = c_in;
    end
  end
endmodule

// File: rtl/shift_carry_unit.sv
module shift_carry_unit
  import shu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 6,
  parameter int AMT_W   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        op_sel,
  input  logic              use_reg_amt,
  input  logic [IMM_W-1:0]  imm_amt,
  input  logic [DATA_W-1:0] rs_val,
  input  logic [DATA_W-1:0] operand,
  input  logic              carry_in,
  input  logic              set_flags,
  input  logic              n_in,
  input  logic              z_in,
  input  logic              v_in,
  output logic [DATA_W-1:0] result,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_c,
  output logic              flag_v
);
  logic [AMT_W-1:0]  amt_w;
  logic [DATA_W-1:0] res_w;
  logic              cout_w, n_w, z_w, c_w;

  shu_amt_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W), .AMT_W(AMT_W)) u_amt (
    .use_reg (use_reg_amt),
    .imm_amt (imm_amt),
    .rs_val  (rs_val),
    .amt     (amt_w)
  );

  shu_core #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_core (
    .op   (op_sel),
    .amt  (amt_w),
    .a    (operand),
    .cin  (carry_in),
    .res  (res_w),
    .cout (cout_w)
  );

  shu_flags #(.DATA_W(DATA_W)) u_flags (
    .set_flags (set_flags),
    .res       (res_w),
    .cout      (cout_w),
    .n_in      (n_in),
    .z_in      (z_in),
    .c_in      (carry_in),
    .n_out     (n_w),
    .z_out     (z_w),
    .c_out     (c_w)
  );

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          result <= '0;
          flag_n <= 1'b0;
          flag_z <= 1'b0;
          flag_c <= 1'b0;
          flag_v <= 1'b0;
        end else begin
          result <= res_w;
          flag_n <= n_w;
          flag_z <= z_w;
          flag_c <= c_w;
          flag_v <= v_in;
        end
      end

      AST_V_PASS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (flag_v == $past(v_in))); // R9
      AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (rst)
        !set_flags |=> (flag_n == $past(n_in) && flag_z == $past(z_in)
                        && flag_c == $past(carry_in))); // R8
      AST_N_TRACKS: assert property (@(posedge clk) disable iff (rst)
        set_flags |=> (flag_n == result[DATA_W-1])); // R8
      AST_Z_TRACKS: assert property (@(posedge clk) disable iff (rst)
        set_flags |=> (flag_z == (result == '0))); // R8
      AST_RRX_TOP: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 3'(OP_RRX)) |=> (result[DATA_W-1] == $past(carry_in))); // R4
      AST_ZERO_AMT: assert property (@(posedge clk) disable iff (rst)
        (op_sel < 3'd4 && amt_w == '0) |=> (result == $past(operand))); // R2
    end else begin : g_comb
      assign result = res_w;
      assign flag_n = n_w;
      assign flag_z = z_w;
      assign flag_c = c_w;
      assign flag_v = v_in;
    end
  endgenerate
endmodule

// File: tb/shift_carry_unit_test.sv
`timescale 1ns/1ps
module shift_carry_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  op_sel = '0;
  logic        use_reg_amt = 1'b0;
  logic [5:0]  imm_amt = '0;
  logic [31:0] rs_val = '0;
  logic [31:0] operand = '0;
  logic        carry_in = 1'b0, set_flags = 1'b0, n_in = 1'b0, z_in = 1'b0, v_in = 1'b0;
  logic [31:0] result;
  logic        flag_n, flag_z, flag_c, flag_v;

  int vectors = 0;
  int miscompares = 0;

  always #2 clk = ~clk;

  shift_carry_unit uut (
    .clk(clk), .rst(rst), .op_sel(op_sel), .use_reg_amt(use_reg_amt),
    .imm_amt(imm_amt), .rs_val(rs_val), .operand(operand), .carry_in(carry_in),
    .set_flags(set_flags), .n_in(n_in), .z_in(z_in), .v_in(v_in),
    .result(result), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
  );

  // Bit-serial reference: repeat a one-place step n times.
  task automatic ref_model(input logic [2:0] op, input int n, input logic [31:0] a,
                           input logic ci, output logic [31:0] r, output logic co);
    r = a; co = ci;
    if (op == 3'd4) begin
      co = a[0]; r = {ci, a[31:1]};
    end else if (op < 3'd4) begin
      for (int i = 0; i < n; i++) begin
        case (op)
          3'd0: begin co = r[31]; r = {r[30:0], 1'b0}; end
          3'd1: begin co = r[0];  r = {1'b0, r[31:1]}; end
          3'd2: begin co = r[0];  r = {r[31], r[31:1]}; end
          default: begin co = r[0]; r = {r[0], r[31:1]}; end
        endcase
      end
    end
  endtask

  task automatic check(input string tag, input logic [35:0] got, input logic [35:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic apply(input string tag, input logic [2:0] op, input logic ur,
                       input logic [5:0] imm, input logic [31:0] rs, input logic [31:0] a,
                       input logic ci, input logic sf, input logic ni, input logic zi,
                       input logic vi);
    logic [31:0] er; logic ec; int n;
    @(negedge clk);
    op_sel = op; use_reg_amt = ur; imm_amt = imm; rs_val = rs; operand = a;
    carry_in = ci; set_flags = sf; n_in = ni; z_in = zi; v_in = vi;
    n = ur ? int'(rs[7:0]) : int'(imm);
    ref_model(op, n, a, ci, er, ec);
    @(negedge clk);
    if (sf) check(tag, {result, flag_n, flag_z, flag_c, flag_v}, {er, er[31], er == 32'd0, ec, vi});
    else    check(tag, {result, flag_n, flag_z, flag_c, flag_v}, {er, ni, zi, ci, vi});
  endtask

  task automatic t_reset();
    apply("R10 load", 3'd0, 1'b0, 6'd4, 32'd0, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R10 reset clears", {result, flag_n, flag_z, flag_c, flag_v}, 36'd0);
    rst = 1'b0;
  endtask

  task automatic t_logical();
    apply("R1 lsl1",  3'd0, 1'b0, 6'd1,  32'd0, 32'h8000_0001, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    apply("R1 lsl31", 3'd0, 1'b0, 6'd31, 32'd0, 32'h0000_0003, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    apply("R1 lsr1",  3'd1, 1'b0, 6'd1,  32'd0, 32'h8000_0001, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    apply("R1 lsr13", 3'd1, 1'b1, 6'd0,  32'd13, 32'hDEAD_BEEF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_zero_amt();
    apply("R2 lsl0 move", 3'd0, 1'b0, 6'd0, 32'd0, 32'h1234_5678, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    apply("R2 asr0 reg",  3'd2, 1'b1, 6'd9, 32'hAB00, 32'h8765_4321, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    apply("R2 ror0",      3'd3, 1'b0, 6'd0, 32'd0, 32'hF000_000F, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_large();
    apply("R3 lsl32", 3'd0, 1'b0, 6'd32, 32'd0, 32'h0000_0001, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    apply("R3 lsr32", 3'd1, 1'b0, 6'd32, 32'd0, 32'h8000_0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    apply("R3 lsl33", 3'd0, 1'b1, 6'd0, 32'd33, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    apply("R3 lsr255", 3'd1, 1'b1, 6'd0, 32'd255, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_rrx();
    apply("R4 rrx c1", 3'd4, 1'b0, 6'd17, 32'd0, 32'h0000_0002, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    apply("R4 rrx c0", 3'd4, 1'b1, 6'd0, 32'd200, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_asr();
    apply("R5 asr4 neg",  3'd2, 1'b0, 6'd4,  32'd0, 32'h8000_0018, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    apply("R5 asr31 pos", 3'd2, 1'b0, 6'd31, 32'd0, 32'h4000_0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    apply("R5 asr32 neg", 3'd2, 1'b0, 6'd32, 32'd0, 32'h8000_0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    apply("R5 asr200",    3'd2, 1'b1, 6'd0,  32'd200, 32'h9000_0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    apply("R5 asr40 pos", 3'd2, 1'b1, 6'd0,  32'd40, 32'h7FFF_FFFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_ror();
    apply("R6 ror8",  3'd3, 1'b0, 6'd8,  32'd0, 32'h1234_5680, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    apply("R6 ror31", 3'd3, 1'b0, 6'd31, 32'd0, 32'h0000_0001, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    apply("R6 ror32", 3'd3, 1'b0, 6'd32, 32'd0, 32'h8000_1234, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    apply("R6 ror64", 3'd3, 1'b1, 6'd0,  32'd64, 32'h7000_0001, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    apply("R6 ror36", 3'd3, 1'b1, 6'd0,  32'd36, 32'h0000_00F8, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_source();
    apply("R7 hi bits ignored", 3'd0, 1'b1, 6'd1, 32'hFFFF_FF04, 32'h0000_00FF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    apply("R7 rs ignored imm",  3'd1, 1'b0, 6'd3, 32'h0000_0010, 32'h0000_00FF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_flags();
    apply("R8 zero result", 3'd1, 1'b0, 6'd8, 32'd0, 32'h0000_0080, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    apply("R8 no set hold", 3'd0, 1'b0, 6'd1, 32'd0, 32'h8000_0000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    apply("R8 no set hold2", 3'd1, 1'b0, 6'd32, 32'd0, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_vpass();
    apply("R9 v one",  3'd0, 1'b0, 6'd2, 32'd0, 32'h0000_0001, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    apply("R9 v zero", 3'd2, 1'b0, 6'd2, 32'd0, 32'h8000_0001, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_badop();
    apply("R11 op5", 3'd5, 1'b0, 6'd7, 32'd0, 32'hCAFE_0001, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    apply("R11 op7", 3'd7, 1'b1, 6'd0, 32'd9, 32'h0000_0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #(4 * 20000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset state", {result, flag_n, flag_z, flag_c, flag_v}, 36'd0);
    rst = 1'b0;
    t_logical();
    t_zero_amt();
    t_large();
    t_rrx();
    t_asr();
    t_ror();
    t_source();
    t_flags();
    t_vpass();
    t_badop();
    t_reset();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule